// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block is the controller side of a serial flash read path. A single `start` pulse, qualified by a read-variant code, a start address, a byte count and a dummy-clock count, makes the block select the flash, shift out the read opcode, send the address, wait out the dummy clocks and then collect the requested number of bytes. Each byte is handed to the fabric as a one-cycle `rd_valid` strobe with `rd_data`.

Five read variants are supported. In every one the opcode goes out on one line. The two "output" variants send the address on one line and receive data on two or four lines. The two "I/O" variants use two or four lines for both the address and the data. The pads are modelled as separate output, output-enable and input vectors, one bit per lane, so the pad ring builds the tri-state buffers. The serial clock runs at half the system clock in SPI mode 0.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset and whenever no read is in progress, `cs_n` is 1, `sclk` is 0, `sio_oe` is 0000, `done` and `rd_valid` are 0.
- R2: The opcode goes out MSB first on lane 0 only, with `sio_oe` = 0001. The `mode` codes and opcodes are: 0 single = 0x03, 1 dual-output = 0x3B, 2 dual-I/O = 0xBB, 3 quad-output = 0x6B, 4 quad-I/O = 0xEB.
- R3: The 24-bit address follows MSB first. Modes 0, 1 and 3 use lane 0 (24 clocks, `sio_oe` = 0001). Mode 2 uses lanes 1:0 (12 clocks, `sio_oe` = 0011, lane 1 carries the higher bit of each pair). Mode 4 uses lanes 3:0 (6 clocks, `sio_oe` = 1111, lane 3 carries the highest bit of each nibble).
- R4: Exactly `dummy` (0 to 15) serial clocks come between the last address clock and the first data clock. `sio_oe` is 0000 from the end of the address until `cs_n` rises.
- R5: Data bytes arrive MSB first. Mode 0 samples lane 1, one bit per clock. Modes 1 and 2 take two bits per clock: lane 1 holds bits 7,5,3,1 and lane 0 holds bits 6,4,2,0. Modes 3 and 4 take four bits per clock: lane 3 holds bits 7,3, lane 2 holds 6,2, lane 1 holds 5,1 and lane 0 holds 4,0.
- R6: SPI mode 0 timing. `sclk` idles low. Each serial clock is one low system cycle followed by one high system cycle. Driven lanes change only while `sclk` is low. `cs_n` is low for exactly 2×(serial clocks)+1 system cycles.
- R7: Exactly `nbytes` bytes are delivered, each as a one-cycle `rd_valid`, from consecutive flash addresses starting at `addr`.
- R8: `cs_n` stays low from the first serial clock until after the last byte. `done` pulses for one cycle, in the first cycle that `cs_n` is high again.
- R9: `start` is ignored while a read is in progress, when `nbytes` is 0, or when `mode` is above 4. An ignored start leaves `cs_n` high, or leaves the running read unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a read (one-cycle pulse) |
| mode | input | 3 | Read variant code, 0..4 |
| addr | input | 24 | First flash byte address |
| nbytes | input | 16 | Number of bytes to read |
| dummy | input | 4 | Dummy serial clocks before data |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | Read finished, one-cycle pulse |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low flash select |
| sio_out | output | 4 | Lane output values |
| sio_oe | output | 4 | Lane output enables |
| sio_in | input | 4 | Lane input values |

## Verification
A bench flash model checks the opcode and address bit by bit at each rising serial clock and returns data on the lanes of the selected variant. It places inverted or junk values on the unused lanes, so a design that samples the wrong lane, or swaps the lane order inside a pair or nibble, delivers wrong bytes. Zero and fifteen dummy clocks are run in every variant. A design that skips the dummy phase or lengthens it by one clock is off by one data slot, and a design that still drives lanes during the turnaround is caught by the enable checks. Start pulses with a bad mode, with a zero count and in the middle of a read are also issued. A design that accepts any of them either lowers `cs_n` when it should not or corrupts the bytes of the read in progress.

// File: rtl/sfr_pkg.sv
// Shared types and helpers for the multi-lane flash read sequencer.
// Assumes 8-bit opcodes and bytes, and at most four data lanes.
package sfr_pkg;
    typedef enum logic [2:0] {
        RD_X1     = 3'd0,
        RD_X2_OUT = 3'd1,
        RD_X2_IO  = 3'd2,
        RD_X4_OUT = 3'd3,
        RD_X4_IO  = 3'd4
    } rd_kind_e;

    // Lane count as a log2 code, so a shift by the code divides by the lane count.
    typedef enum logic [1:0] {
        LN_1 = 2'd0,
        LN_2 = 2'd1,
        LN_4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_FINISH
    } seq_st_e;

    function automatic logic [7:0] opcode_of(rd_kind_e k);
        case (k)
            RD_X2_OUT: return 8'h3B;
            RD_X2_IO:  return 8'hBB;
            RD_X4_OUT: return 8'h6B;
            RD_X4_IO:  return 8'hEB;
            default:   return 8'h03;
        endcase
    endfunction

    function automatic lane_e addr_lanes(rd_kind_e k);
        case (k)
            RD_X2_IO: return LN_2;
            RD_X4_IO: return LN_4;
            default:  return LN_1;
        endcase
    endfunction

    function automatic lane_e data_lanes(rd_kind_e k);
        case (k)
            RD_X2_OUT, RD_X2_IO: return LN_2;
            RD_X4_OUT, RD_X4_IO: return LN_4;
            default:             return LN_1;
        endcase
    endfunction
endpackage

// File: rtl/sfr_tx_shift.sv
// Outbound shift register for the opcode and address.
// It loads {opcode, address} once and moves 1, 2 or 4 bits per serial clock
// toward the MSB. The top bits are placed on the lanes, with the highest bit
// on the highest lane. A lane shows 0 when its enable is off.
module sfr_tx_shift
    import sfr_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift,
    input  lane_e           lanes,
    input  logic [3:0]      oe_mask,
    output logic [3:0]      sio_out,
    output logic [3:0]      sio_oe
);
    logic [SR_W-1:0] sr;
    logic [3:0]      raw;

    // Load a fresh header, or advance by the active lane count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            case (lanes)
                LN_1:    sr <= {sr[SR_W-2:0], 1'b0};
                LN_2:    sr <= {sr[SR_W-3:0], 2'b0};
                default: sr <= {sr[SR_W-5:0], 4'b0};
            endcase
        end
    end

    // Map the leading bits onto the lanes.
    always_comb begin
        case (lanes)
            LN_1:    raw = {3'b000, sr[SR_W-1]};
            LN_2:    raw = {2'b00, sr[SR_W-1 -: 2]};
            default: raw = sr[SR_W-1 -: 4];
        endcase
    end

    assign sio_out = raw & oe_mask;
    assign sio_oe  = oe_mask;
endmodule

// File: rtl/sfr_rx_shift.sv
// Inbound byte assembler.
// On each capture it appends 1 bit (lane 1), 2 bits (lanes 1:0) or 4 bits
// (lanes 3:0) at the LSB end. On the last capture of a byte it publishes the
// byte with a one-cycle valid. Assumes 8/lanes captures make up each byte.
module sfr_rx_shift
    import sfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap,
    input  logic       last,
    input  lane_e      lanes,
    input  logic [3:0] sio_in,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    logic [7:0] sr;
    logic [7:0] nxt;

    // Next byte image after appending the sampled lanes.
    always_comb begin
        case (lanes)
            LN_1:    nxt = {sr[6:0], sio_in[1]};
            LN_2:    nxt = {sr[5:0], sio_in[1:0]};
            default: nxt = {sr[3:0], sio_in};
        endcase
    end

    // Accumulate the sampled bits and publish completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap && last;
            if (cap) begin
                sr <= nxt;
            end
            if (cap && last) begin
                rd_data <= nxt;
            end
        end
    end
endmodule

// File: rtl/sfr_seq.sv
// Phase sequencer: command, address, dummy, data, finish.
// Generates the mode-0 serial clock at half the system rate, holds the select
// low, and tells the shift registers when to move and on how many lanes.
// The drive update and the input sample both happen at the edge that ends the
// high half of a serial clock.
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NB_W   = 16,
    parameter int DUM_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [NB_W-1:0]  nbytes,
    input  logic [DUM_W-1:0] dummy,
    output logic             sclk,
    output logic             cs_n,
    output logic             done,
    output logic             tx_load,
    output logic             tx_shift,
    output lane_e            tx_lanes,
    output logic [3:0]       oe_mask,
    output logic             rx_cap,
    output logic             rx_last,
    output lane_e            rx_lanes
);
    localparam int AW_LOG = $clog2(ADDR_W);
    localparam int CNT_W  = (AW_LOG > DUM_W) ? AW_LOG : DUM_W;

    seq_st_e          st;
    rd_kind_e         kind_q;
    logic [DUM_W-1:0] dum_q;
    logic [NB_W-1:0]  left;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] byte_last;
    logic             sclk_q, cs_q, done_q;
    logic             go;
    logic             cnt_end;

    // A start is taken only in idle, with a nonzero count and a known mode.
    assign go      = start && (st == S_IDLE) && (nbytes != '0) && (mode <= 3'd4);
    assign cnt_end = (cnt == '0);

    // Serial-clock counts for the address and for one byte of data.
    always_comb begin
        case (addr_lanes(kind_q))
            LN_1:    addr_last = CNT_W'(ADDR_W - 1);
            LN_2:    addr_last = CNT_W'(ADDR_W / 2 - 1);
            default: addr_last = CNT_W'(ADDR_W / 4 - 1);
        endcase
        case (data_lanes(kind_q))
            LN_1:    byte_last = CNT_W'(7);
            LN_2:    byte_last = CNT_W'(3);
            default: byte_last = CNT_W'(1);
        endcase
    end

    // Phase state, serial clock, select and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            kind_q <= RD_X1;
            dum_q  <= '0;
            left   <= '0;
            cnt    <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (go) begin
                        kind_q <= rd_kind_e'(mode);
                        dum_q  <= dummy;
                        left   <= nbytes;
                        cnt    <= CNT_W'(7);
                        cs_q   <= 1'b0;
                        st     <= S_CMD;
                    end
                end
                S_FINISH: begin
                    cs_q   <= 1'b1;
                    done_q <= 1'b1;
                    st     <= S_IDLE;
                end
                default: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (!cnt_end) begin
                            cnt <= cnt - CNT_W'(1);
                        end else begin
                            case (st)
                                S_CMD: begin
                                    st  <= S_ADDR;
                                    cnt <= addr_last;
                                end
                                S_ADDR: begin
                                    if (dum_q != '0) begin
                                        st  <= S_DUMMY;
                                        cnt <= CNT_W'(dum_q) - CNT_W'(1);
                                    end else begin
                                        st  <= S_DATA;
                                        cnt <= byte_last;
                                    end
                                end
                                S_DUMMY: begin
                                    st  <= S_DATA;
                                    cnt <= byte_last;
                                end
                                default: begin
                                    if (left == NB_W'(1)) begin
                                        st <= S_FINISH;
                                    end else begin
                                        left <= left - NB_W'(1);
                                        cnt  <= byte_last;
                                    end
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Strobes and lane selection for the shift registers.
    always_comb begin
        tx_load  = go;
        tx_shift = sclk_q && ((st == S_CMD) || (st == S_ADDR));
        tx_lanes = (st == S_ADDR) ? addr_lanes(kind_q) : LN_1;
        rx_cap   = sclk_q && (st == S_DATA);
        rx_last  = cnt_end;
        rx_lanes = data_lanes(kind_q);
        case (st)
            S_CMD: oe_mask = 4'b0001;
            S_ADDR: begin
                case (addr_lanes(kind_q))
                    LN_1:    oe_mask = 4'b0001;
                    LN_2:    oe_mask = 4'b0011;
                    default: oe_mask = 4'b1111;
                endcase
            end
            default: oe_mask = 4'b0000;
        endcase
    end

    assign sclk = sclk_q;
    assign cs_n = cs_q;
    assign done = done_q;
endmodule

// File: rtl/sfr_read_engine.sv
// Top level of the multi-lane serial flash read sequencer.
// Joins the phase sequencer to the outbound header shifter and the inbound
// byte assembler. Pads are split into output, enable and input vectors.
module sfr_read_engine
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NB_W   = 16,
    parameter int DUM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB_W-1:0]   nbytes,
    input  logic [DUM_W-1:0]  dummy,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        sio_out,
    output logic [3:0]        sio_oe,
    input  logic [3:0]        sio_in
);
    localparam int HDR_W = 8 + ADDR_W;

    logic             tx_load, tx_shift, rx_cap, rx_last;
    lane_e            tx_lanes, rx_lanes;
    logic [3:0]       oe_mask;
    logic [HDR_W-1:0] hdr;

    // Header image: opcode of the requested variant followed by the address.
    assign hdr = {opcode_of(rd_kind_e'(mode)), addr};

    sfr_seq #(.ADDR_W(ADDR_W), .NB_W(NB_W), .DUM_W(DUM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .nbytes(nbytes), .dummy(dummy), .sclk(sclk), .cs_n(cs_n),
        .done(done), .tx_load(tx_load), .tx_shift(tx_shift),
        .tx_lanes(tx_lanes), .oe_mask(oe_mask), .rx_cap(rx_cap),
        .rx_last(rx_last), .rx_lanes(rx_lanes)
    );

    sfr_tx_shift #(.SR_W(HDR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(hdr),
        .shift(tx_shift), .lanes(tx_lanes), .oe_mask(oe_mask),
        .sio_out(sio_out), .sio_oe(sio_oe)
    );

    sfr_rx_shift u_rx (
        .clk(clk), .rst_n(rst_n), .cap(rx_cap), .last(rx_last),
        .lanes(rx_lanes), .sio_in(sio_in), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/sfr_read_engine_chk.sv
// Protocol checker bound to the read sequencer top.
// Assumes the synchronous active-low reset of the top.
module sfr_read_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       cs_n,
    input logic       done,
    input logic       rd_valid,
    input logic [3:0] sio_out,
    input logic [3:0] sio_oe
);
    // Deselected means quiet: clock low, no lane driven.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && (sio_oe == 4'b0000)));

    // Lanes hold steady through every high half of the serial clock.
    assert_drive_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> ($stable(sio_out) && $stable(sio_oe)));

    // The high half lasts exactly one system cycle.
    assert_high_half_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    // No lane is driven while a received byte is presented.
    assert_released_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (sio_oe == 4'b0000));

    // Bytes are only delivered while the flash is selected.
    assert_byte_under_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    // Completion follows the select rising and lasts one cycle.
    assert_done_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sfr_read_engine sfr_read_engine_chk u_chk (.*);

// File: tb/tb_sfr_read_engine.sv
// Bench for the read sequencer: a behavioural flash model plus directed and
// seeded random reads, checked against expected values computed here.
module tb_sfr_read_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [23:0] addr = '0;
    logic [15:0] nbytes = '0;
    logic [3:0]  dummy = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, done, sclk, cs_n;
    logic [3:0]  sio_out, sio_oe;
    logic [3:0]  sio_in = 4'b1010;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sfr_read_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr(addr),
        .nbytes(nbytes), .dummy(dummy), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out),
        .sio_oe(sio_oe), .sio_in(sio_in)
    );

    // Flash content as a pure function of the address.
    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] ^ {a[12:8], a[23:21]} ^ {a[19:16], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_op(input int m);
        case (m)
            1: return 8'h3B;
            2: return 8'hBB;
            3: return 8'h6B;
            4: return 8'hEB;
            default: return 8'h03;
        endcase
    endfunction

    function automatic int exp_alanes(input int m);
        return (m == 2) ? 2 : (m == 4) ? 4 : 1;
    endfunction

    function automatic int exp_dlanes(input int m);
        return (m == 0) ? 1 : (m <= 2) ? 2 : 4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Flash model state.
    int          m_al = 1, m_dl = 1, m_dummy = 0;
    logic [23:0] m_base = '0;
    int          rises = 0, dclk = 0, last_rises = 0, cs_cycles = 0;
    int          oe_addr_err = 0, oe_rel_err = 0;
    logic [7:0]  cmd_got = '0;
    logic [23:0] addr_got = '0;
    logic        sclk_prev = 1'b0, cs_prev = 1'b1;

    // Flash model: sample at rising serial clock, drive after falling.
    always @(negedge clk) begin
        if (cs_n) begin
            if (rises != 0) last_rises = rises;
            rises = 0;
            dclk = 0;
            sio_in = 4'b1010;
        end else begin
            if (cs_prev) cs_cycles = 0;
            cs_cycles++;
            if (sclk && !sclk_prev) begin
                rises++;
                if (rises <= 8) begin
                    cmd_got = {cmd_got[6:0], sio_out[0]};
                    if (sio_oe != 4'b0001) oe_addr_err++;
                end else if (rises <= 8 + 24 / m_al) begin
                    if (m_al == 1) begin
                        addr_got = {addr_got[22:0], sio_out[0]};
                        if (sio_oe != 4'b0001) oe_addr_err++;
                    end else if (m_al == 2) begin
                        addr_got = {addr_got[21:0], sio_out[1:0]};
                        if (sio_oe != 4'b0011) oe_addr_err++;
                    end else begin
                        addr_got = {addr_got[19:0], sio_out};
                        if (sio_oe != 4'b1111) oe_addr_err++;
                    end
                end else if (sio_oe != 4'b0000) begin
                    oe_rel_err++;
                end
            end
            if (!sclk && sclk_prev && rises >= 8 + 24 / m_al + m_dummy) begin
                int per, w, grp;
                logic [7:0] b;
                per = 8 / m_dl;
                w = dclk % per;
                b = fmem(m_base + 24'(dclk / per));
                grp = (int'(b) >> (8 - m_dl * (w + 1))) & ((1 << m_dl) - 1);
                if (m_dl == 1)      sio_in = {2'b10, grp[0], ~grp[0]};
                else if (m_dl == 2) sio_in = {2'b01, grp[1:0]};
                else                sio_in = grp[3:0];
                dclk++;
            end
        end
        sclk_prev = sclk;
        cs_prev = cs_n;
    end

    // Byte collector: each delivered byte against the flash function (R5, R7).
    int          got_n = 0;
    logic [23:0] exp_base = '0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            chk("R5 byte value", {24'h0, rd_data}, {24'h0, fmem(exp_base + 24'(got_n))});
            got_n++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_txn(input int m, input logic [23:0] a, input int n,
                           input int d, input bit poke);
        int wait_c;
        int hi_bad;
        m_al = exp_alanes(m);
        m_dl = exp_dlanes(m);
        m_dummy = d;
        m_base = a;
        exp_base = a;
        got_n = 0;
        oe_addr_err = 0;
        oe_rel_err = 0;
        @(negedge clk);
        mode = 3'(m);
        addr = a;
        nbytes = 16'(n);
        dummy = 4'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            mode = 3'd0;
            addr = ~a;
            nbytes = 16'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_c = 0;
        while (!done && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
        end
        chk("R8 select high at done", {31'h0, cs_n}, 32'h1);
        @(negedge clk);
        chk("R8 done single cycle", {31'h0, done}, 32'h0);
        chk("R2 opcode", {24'h0, cmd_got}, {24'h0, exp_op(m)});
        chk("R3 address", {8'h0, addr_got}, {8'h0, a});
        chk("R3 address lane enables", oe_addr_err, 0);
        chk("R4 released during dummy and data", oe_rel_err, 0);
        chk("R7 byte count", got_n, n);
        chk("R4 serial clock total", last_rises, 8 + 24 / m_al + d + n * 8 / m_dl);
        chk("R6 select low cycles", cs_cycles, 2 * last_rises + 1);
        if (poke) begin
            hi_bad = 0;
            repeat (12) begin
                @(negedge clk);
                if (!cs_n) hi_bad++;
            end
            chk("R9 start during read ignored", hi_bad, 0);
        end
    endtask

    task automatic try_ignored(input int m, input int n);
        int low_c;
        low_c = 0;
        @(negedge clk);
        mode = 3'(m);
        nbytes = 16'(n);
        addr = 24'h123456;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (!cs_n || sclk || sio_oe != 4'b0000) low_c++;
        end
        chk("R9 rejected start keeps idle", low_c, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset select", {31'h0, cs_n}, 32'h1);
        chk("R1 reset clock", {31'h0, sclk}, 32'h0);
        chk("R1 reset enables", {28'h0, sio_oe}, 32'h0);
        chk("R1 reset strobes", {30'h0, done, rd_valid}, 32'h0);

        // Every variant at both dummy extremes.
        for (int m = 0; m < 5; m++) begin
            run_txn(m, 24'hA5C30F ^ 24'(m), 2, 0, 1'b0);
            run_txn(m, 24'h0FF0F0 + 24'(m), 1, 15, 1'b0);
        end
        run_txn(4, 24'hFFFFFE, 20, 6, 1'b0);
        run_txn(2, 24'h800001, 5, 4, 1'b1);

        try_ignored(5, 4);
        try_ignored(7, 4);
        try_ignored(1, 0);

        for (int i = 0; i < 25; i++) begin
            run_txn(int'($urandom % 5), 24'($urandom), 1 + int'($urandom % 6),
                    int'($urandom % 16), 1'b0);
        end

        // Back in idle after everything.
        @(negedge clk);
        chk("R1 idle after reads", {30'h0, cs_n, sclk}, 32'h2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule